// File: doc/BRIEF.md
# Gate-Local Fault Test Vector Generator

This block serves a test generator for reversible circuits built from multiple-control Toffoli gates. It is given the control-line mask and the target line of one gate, plus a fault model and a faulty line. It returns the line state that must sit at that gate's input for the fault to show at the outputs. Three fault models are handled: the whole gate not being evaluated, one control connection being lost, and one extra control connection appearing. The lines a fault does not pin down are filled by a chosen policy: all zeros, all ones, or bits from an on-chip pseudo-random generator.

A request is taken in one of two modes. A single request yields one vector in the following cycle. An enumeration request walks every fault of the chosen model for the gate, one vector per cycle, and marks the final one. The block does not drive vectors back to the primary inputs and does not simulate faults. A separate engine uses the vectors for that.

Top module: `rvtg_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `ready` is 1 and `out_valid`, `out_last` and `out_invalid` are 0.
- R2: With fault code 0 (gate not evaluated), every line set in the control mask is 1 in the vector, and `out_line` is 0.
- R3: With fault code 1 (lost control on line L), every control other than L is 1, line L is 0, and `out_line` is L.
- R4: With fault code 2 (extra control on line L), every existing control is 1, line L is 0, and `out_line` is L.
- R5: The lines that no fault rule fixes, the target included, follow the fill code: 0 gives all zeros, 1 gives all ones, and 3 acts as 0.
- R6: Fill code 2 takes line i from bit i mod 16 of a 16-bit register. The register is seeded to 0xACE1 at reset. It advances as s <= {s[14:0], s[15]^s[14]^s[12]^s[3]} once for each vector emitted with `out_invalid` at 0, whatever the fill code. The register is never 0.
- R7: A request is invalid in any of these cases: the mask contains the target; the fault code is 3; a lost-control line is not a control; an extra-control line is the target or an existing control. An invalid request gives one output with `out_invalid`=1, `out_last`=1, an all-zero vector and `out_line`=0. It does not advance the random register.
- R8: Enumeration of fault code 1 emits one vector for each control, in ascending line order, with `out_last` only on the final one.
- R9: Enumeration of fault code 2 emits one vector for each line that is neither a control nor the target, in ascending order, with `out_last` only on the final one.
- R10: Enumeration of fault code 0 emits exactly one vector with `out_last`=1. An enumeration that has no candidates gives a single invalid output, as in R7.
- R11: A multi-vector enumeration holds `ready` low for as many cycles as it has vectors and emits one vector in each of those cycles. Requests seen while `ready` is low are ignored.
- R12: A request accepted while `ready` is high yields its single output in the next cycle with `out_last`=1. No output appears in a cycle after an idle one without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when `ready` is 1 |
| req_enum | input | 1 | 1 = enumerate all faults of the model, 0 = single fault |
| req_ctrl_mask | input | N_LINES | Control lines of the gate |
| req_target | input | IW | Target line index |
| req_fault | input | 2 | 0 gate not evaluated, 1 lost control, 2 extra control, 3 reserved |
| req_line | input | IW | Faulty line for codes 1 and 2 in single mode |
| req_fill | input | 2 | 0 zeros, 1 ones, 2 random, 3 zeros |
| ready | output | 1 | Block idle and accepting requests |
| out_valid | output | 1 | Output fields valid this cycle |
| out_vec | output | N_LINES | Gate input state exposing the fault |
| out_invalid | output | 1 | Request rejected, no vector |
| out_last | output | 1 | Final output of the request |
| out_line | output | IW | Faulty line that the vector targets |

## Verification
The hardest situation to reach is a request arriving while an enumeration is still in progress. The stimulus first starts an enumeration of lost controls on a gate with four controls. It then holds a fully formed single request on the inputs in every cycle that `ready` is low. The scoreboard must then see exactly the four enumerated vectors and nothing else, and the number of busy cycles is counted. The random policy is checked bit by bit against a model of the register. Invalid requests are placed just before random-fill requests, so a register step caused by a rejection would show up as a wrong vector.

// File: rtl/rvtg_pkg.sv
package rvtg_pkg;
   typedef enum logic [1:0] {
      FT_GATE  = 2'd0,
      FT_DROP  = 2'd1,
      FT_EXTRA = 2'd2,
      FT_RSVD  = 2'd3
   } fault_e;

   typedef enum logic [1:0] {
      FILL_LOW  = 2'd0,
      FILL_HIGH = 2'd1,
      FILL_PRBS = 2'd2,
      FILL_RSVD = 2'd3
   } fill_e;

   localparam int unsigned PRBS_W = 16;
endpackage

// File: rtl/rvtg_prbs16.sv
module rvtg_prbs16 import rvtg_pkg::*; #(
   parameter logic [PRBS_W-1:0] SEED = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   output logic [PRBS_W-1:0] state
);
   logic [PRBS_W-1:0] s_q;
   logic              fb;

   generate
      if (SEED == '0) begin : g_bad_seed
         $error("rvtg_prbs16: SEED must be nonzero");
      end
   endgenerate

   assign fb = s_q[15] ^ s_q[14] ^ s_q[12] ^ s_q[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_q <= SEED;
      end else if (step) begin
         s_q <= {s_q[PRBS_W-2:0], fb};
      end
   end

   assign state = s_q;
endmodule

// File: rtl/rvtg_first_one.sv
module rvtg_first_one #(
   parameter int unsigned W  = 16,
   localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [W-1:0]  onehot,
   output logic [IW-1:0] idx
);
   logic [W-1:0] seen;

   assign seen[0] = 1'b0;
   generate
      for (genvar gi = 1; gi < W; gi++) begin : g_chain
         assign seen[gi] = seen[gi-1] | vec[gi-1];
      end
   endgenerate

   assign onehot = vec & ~seen;

   always_comb begin
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (onehot[i]) idx = idx | IW'(i);
      end
   end
endmodule

// File: rtl/rvtg_vec_build.sv
module rvtg_vec_build import rvtg_pkg::*; #(
   parameter int unsigned N_LINES = 16
) (
   input  logic [N_LINES-1:0] mask,
   input  fault_e             fault,
   input  logic [N_LINES-1:0] pick,
   input  fill_e              fill,
   input  logic [PRBS_W-1:0]  rnd,
   output logic [N_LINES-1:0] vec
);
   logic [N_LINES-1:0] rnd_ext;
   logic [N_LINES-1:0] fillv;
   logic [N_LINES-1:0] fixed;
   logic [N_LINES-1:0] value;

   generate
      if (N_LINES == PRBS_W) begin : g_fill_same
         assign rnd_ext = rnd;
      end else begin : g_fill_wrap
         for (genvar gi = 0; gi < N_LINES; gi++) begin : g_bit
            assign rnd_ext[gi] = rnd[gi % PRBS_W];
         end
      end
   endgenerate

   always_comb begin
      unique case (fill)
         FILL_HIGH: fillv = '1;
         FILL_PRBS: fillv = rnd_ext;
         default:   fillv = '0;
      endcase
   end

   always_comb begin
      fixed = mask;
      value = mask;
      unique case (fault)
         FT_DROP:  value = mask & ~pick;
         FT_EXTRA: fixed = mask | pick;
         default:  ;
      endcase
   end

   assign vec = (value & fixed) | (fillv & ~fixed);
endmodule

// File: rtl/rvtg_gen.sv
module rvtg_gen import rvtg_pkg::*; #(
   parameter int unsigned       N_LINES = 16,
   parameter logic [PRBS_W-1:0] SEED    = 16'hACE1,
   localparam int unsigned      IW      = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_enum,
   input  logic [N_LINES-1:0] req_ctrl_mask,
   input  logic [IW-1:0]      req_target,
   input  logic [1:0]         req_fault,
   input  logic [IW-1:0]      req_line,
   input  logic [1:0]         req_fill,
   output logic               ready,
   output logic               out_valid,
   output logic [N_LINES-1:0] out_vec,
   output logic               out_invalid,
   output logic               out_last,
   output logic [IW-1:0]      out_line
);
   generate
      if (N_LINES < 2) begin : g_bad_lines
         $error("rvtg_gen: N_LINES must be at least 2");
      end
   endgenerate

   typedef enum logic {ST_IDLE, ST_RUN} st_e;

   st_e                st_q;
   logic [N_LINES-1:0] mask_q, rem_q;
   fault_e             fault_q;
   fill_e              fill_q;

   fault_e             req_ft;
   fill_e              req_fl;
   logic [N_LINES-1:0] line_dec, tgt_dec, cand;
   logic               tgt_hit, tgt_ok, line_ok;
   logic               single_bad, enum_bad;
   logic               run, accept, imm, imm_bad, emit, emit_bad, step;
   logic [N_LINES-1:0] pick_oh;
   logic [IW-1:0]      pick_idx;
   logic [N_LINES-1:0] b_mask, b_pick, built;
   fault_e             b_fault;
   fill_e              b_fill;
   logic [PRBS_W-1:0]  prbs_q;
   logic [IW-1:0]      line_out;
   logic               last_out;

   assign req_ft = fault_e'(req_fault);
   assign req_fl = fill_e'(req_fill);

   generate
      for (genvar gi = 0; gi < N_LINES; gi++) begin : g_dec
         assign line_dec[gi] = (req_line == IW'(gi));
         assign tgt_dec[gi]  = (req_target == IW'(gi));
      end
   endgenerate

   assign tgt_hit = |(req_ctrl_mask & tgt_dec);
   assign tgt_ok  = |tgt_dec;
   assign line_ok = |line_dec;

   always_comb begin
      single_bad = tgt_hit || !tgt_ok;
      unique case (req_ft)
         FT_DROP:  if (!line_ok || ~|(req_ctrl_mask & line_dec)) single_bad = 1'b1;
         FT_EXTRA: if (!line_ok || (line_dec == tgt_dec) ||
                       |(req_ctrl_mask & line_dec)) single_bad = 1'b1;
         FT_RSVD:  single_bad = 1'b1;
         default:  ;
      endcase
   end

   always_comb begin
      unique case (req_ft)
         FT_DROP:  cand = req_ctrl_mask;
         FT_EXTRA: cand = ~req_ctrl_mask & ~tgt_dec;
         default:  cand = '0;
      endcase
      enum_bad = tgt_hit || !tgt_ok || (req_ft == FT_RSVD) ||
                 ((req_ft != FT_GATE) && (cand == '0));
   end

   assign run      = (st_q == ST_RUN);
   assign ready    = !run;
   assign accept   = req_valid && !run;
   assign imm      = accept && (!req_enum || enum_bad || (req_ft == FT_GATE));
   assign imm_bad  = req_enum ? enum_bad : single_bad;
   assign emit     = run || imm;
   assign emit_bad = !run && imm_bad;
   assign step     = emit && !emit_bad;

   rvtg_first_one #(.W(N_LINES)) pick_i (
      .vec    (rem_q),
      .onehot (pick_oh),
      .idx    (pick_idx)
   );

   assign b_mask  = run ? mask_q  : req_ctrl_mask;
   assign b_fault = run ? fault_q : req_ft;
   assign b_fill  = run ? fill_q  : req_fl;
   assign b_pick  = run ? pick_oh : line_dec;

   rvtg_vec_build #(.N_LINES(N_LINES)) build_i (
      .mask  (b_mask),
      .fault (b_fault),
      .pick  (b_pick),
      .fill  (b_fill),
      .rnd   (prbs_q),
      .vec   (built)
   );

   rvtg_prbs16 #(.SEED(SEED)) prbs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .state (prbs_q)
   );

   always_comb begin
      if (run) begin
         line_out = pick_idx;
         last_out = ((rem_q & ~pick_oh) == '0);
      end else begin
         line_out = (imm_bad || (req_ft == FT_GATE)) ? '0 : req_line;
         last_out = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         mask_q      <= '0;
         rem_q       <= '0;
         fault_q     <= FT_GATE;
         fill_q      <= FILL_LOW;
         out_valid   <= 1'b0;
         out_vec     <= '0;
         out_invalid <= 1'b0;
         out_last    <= 1'b0;
         out_line    <= '0;
      end else begin
         out_valid   <= emit;
         out_invalid <= emit && emit_bad;
         out_last    <= emit && last_out;
         if (emit) begin
            out_vec  <= emit_bad ? '0 : built;
            out_line <= line_out;
         end
         if (run) begin
            rem_q <= rem_q & ~pick_oh;
            if (last_out) st_q <= ST_IDLE;
         end else if (accept && !imm) begin
            st_q    <= ST_RUN;
            mask_q  <= req_ctrl_mask;
            rem_q   <= cand;
            fault_q <= req_ft;
            fill_q  <= req_fl;
         end
      end
   end
endmodule

// File: rtl/rvtg_gen_chk.sv
module rvtg_gen_chk #(
   parameter int unsigned N_LINES = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               ready,
   input logic               out_valid,
   input logic               out_last,
   input logic               out_invalid,
   input logic [N_LINES-1:0] out_vec,
   input logic [15:0]        prbs_q
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !req_valid) |=> !out_valid); // R12
   AST_RUN_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> out_valid); // R11
   AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid); // R8
   AST_INVALID_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      out_invalid |-> (out_valid && out_last && (out_vec == '0))); // R7
   AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      prbs_q != 16'h0); // R6
   AST_PRBS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_invalid) |-> !$stable(prbs_q)); // R6
   AST_PRBS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && !out_invalid) |-> $stable(prbs_q)); // R6
endmodule

bind rvtg_gen rvtg_gen_chk #(.N_LINES(N_LINES)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .ready       (ready),
   .out_valid   (out_valid),
   .out_last    (out_last),
   .out_invalid (out_invalid),
   .out_vec     (out_vec),
   .prbs_q      (prbs_q)
);

// File: tb/rvtg_gen_tb_top.sv
`timescale 1ns/1ps
module rvtg_gen_tb_top;
   localparam int N  = 16;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_enum = 1'b0;
   logic [N-1:0]  req_ctrl_mask = '0;
   logic [IW-1:0] req_target = '0;
   logic [1:0]    req_fault = '0;
   logic [IW-1:0] req_line = '0;
   logic [1:0]    req_fill = '0;
   logic          ready, out_valid, out_invalid, out_last;
   logic [N-1:0]  out_vec;
   logic [IW-1:0] out_line;

   always #2.5 clk = ~clk;

   rvtg_gen #(.N_LINES(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_enum(req_enum),
      .req_ctrl_mask(req_ctrl_mask), .req_target(req_target),
      .req_fault(req_fault), .req_line(req_line), .req_fill(req_fill),
      .ready(ready), .out_valid(out_valid), .out_vec(out_vec),
      .out_invalid(out_invalid), .out_last(out_last), .out_line(out_line)
   );

   typedef struct {
      logic [N-1:0]  vec;
      logic          inv;
      logic          last;
      logic [IW-1:0] line;
      string         tag;
   } item_t;

   item_t        sb_q[$];
   int           total = 0;
   int           bad = 0;
   bit           reported = 0;
   logic [15:0]  m_prbs = 16'hACE1;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   function automatic logic [15:0] prbs_next(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
   endfunction

   // expected vector from the fault rules and the fill policy
   function automatic logic [N-1:0] model_vec(input logic [N-1:0] m,
      input logic [1:0] f, input int l, input logic [1:0] fl, input logic [15:0] r);
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) begin
         if (m[i])                    v[i] = !(f == 2'd1 && i == l);
         else if (f == 2'd2 && i == l) v[i] = 1'b0;
         else if (fl == 2'd1)         v[i] = 1'b1;
         else if (fl == 2'd2)         v[i] = r[i % 16];
         else                         v[i] = 1'b0;
      end
      return v;
   endfunction

   function automatic void push_vec(input logic [N-1:0] m, input logic [1:0] f,
      input int l, input logic [1:0] fl, input logic last, input string tag);
      item_t it;
      it.vec  = model_vec(m, f, l, fl, m_prbs);
      it.inv  = 1'b0;
      it.last = last;
      it.line = (f == 2'd0) ? '0 : IW'(l);
      it.tag  = tag;
      m_prbs  = prbs_next(m_prbs);
      sb_q.push_back(it);
   endfunction

   function automatic void push_bad(input string tag);
      item_t it;
      it.vec = '0; it.inv = 1'b1; it.last = 1'b1; it.line = '0; it.tag = tag;
      sb_q.push_back(it);
   endfunction

   task automatic drive(input logic en, input logic [N-1:0] m, input int t,
      input logic [1:0] f, input int l, input logic [1:0] fl);
      @(negedge clk);
      while (!ready) @(negedge clk);
      req_enum = en; req_ctrl_mask = m; req_target = IW'(t);
      req_fault = f; req_line = IW'(l); req_fill = fl; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic single(input logic [N-1:0] m, input int t, input logic [1:0] f,
      input int l, input logic [1:0] fl, input string tag);
      bit badreq;
      badreq = m[t] || (f == 2'd3) || (f == 2'd1 && !m[l]) ||
               (f == 2'd2 && (l == t || m[l]));
      if (badreq) push_bad(tag);
      else        push_vec(m, f, l, fl, 1'b1, tag);
      drive(1'b0, m, t, f, l, fl);
      chk(out_valid === 1'b1, "R12 single latency", {31'd0, out_valid}, 32'd1);
   endtask

   function automatic int push_enum(input logic [N-1:0] m, input int t,
      input logic [1:0] f, input logic [1:0] fl, input string tag);
      int cnt = 0, seen = 0;
      logic [N-1:0] c = '0;
      if (m[t] || f == 2'd3) begin push_bad(tag); return 0; end
      if (f == 2'd0) begin push_vec(m, f, 0, fl, 1'b1, tag); return 0; end
      for (int i = 0; i < N; i++)
         c[i] = (f == 2'd1) ? m[i] : (!m[i] && i != t);
      for (int i = 0; i < N; i++) if (c[i]) cnt++;
      if (cnt == 0) begin push_bad(tag); return 0; end
      for (int i = 0; i < N; i++) begin
         if (c[i]) begin
            seen++;
            push_vec(m, f, i, fl, seen == cnt, tag);
         end
      end
      return cnt;
   endfunction

   // monitor: pop and compare every output
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R11 unexpected output", {16'd0, out_vec}, 32'd0);
         end else begin
            item_t e;
            e = sb_q.pop_front();
            chk(out_vec === e.vec && out_invalid === e.inv &&
                out_last === e.last && out_line === e.line, e.tag,
                {out_invalid, out_last, 6'd0, out_line, 4'd0, out_vec},
                {e.inv, e.last, 6'd0, e.line, 4'd0, e.vec});
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      report();
   end

   initial begin
      int n, busy;
      repeat (3) @(negedge clk);
      chk(ready === 1'b1 && out_valid === 1'b0, "R1 in reset",
          {30'd0, ready, out_valid}, 32'd2);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready === 1'b1 && out_valid === 1'b0 && out_last === 1'b0 &&
          out_invalid === 1'b0, "R1 after reset",
          {28'd0, ready, out_valid, out_last, out_invalid}, 32'd8);

      single(16'h00F0, 2, 2'd0, 0, 2'd0, "R2 gate zero fill R5");
      single(16'h00F0, 2, 2'd0, 7, 2'd1, "R2 gate one fill R5");
      single(16'h0C11, 15, 2'd1, 10, 2'd1, "R3 drop ctrl one fill");
      single(16'h0C11, 15, 2'd1, 0, 2'd3, "R3 drop ctrl fill code 3 R5");
      single(16'h0003, 4, 2'd2, 9, 2'd0, "R4 extra ctrl zero fill");
      single(16'h0003, 4, 2'd2, 15, 2'd1, "R4 extra ctrl one fill");
      single(16'h1248, 0, 2'd0, 0, 2'd2, "R6 random gate");
      single(16'h1248, 0, 2'd1, 6, 2'd2, "R6 random drop");

      single(16'h0003, 4, 2'd2, 4, 2'd2, "R7 extra on target");
      single(16'h0003, 4, 2'd2, 1, 2'd2, "R7 extra on control");
      single(16'h0003, 4, 2'd1, 5, 2'd2, "R7 drop on non-control");
      single(16'h0013, 4, 2'd0, 0, 2'd2, "R7 mask holds target");
      single(16'h0003, 4, 2'd3, 0, 2'd2, "R7 reserved fault");
      single(16'h0003, 4, 2'd2, 12, 2'd2, "R6 R7 no step on reject");

      n = push_enum(16'h8421, 1, 2'd1, 2'd1, "R8 enum drop");
      drive(1'b1, 16'h8421, 1, 2'd1, 0, 2'd1);
      n = push_enum(16'h00F0, 0, 2'd2, 2'd2, "R9 enum extra random");
      drive(1'b1, 16'h00F0, 0, 2'd2, 0, 2'd2);
      n = push_enum(16'h0606, 0, 2'd0, 2'd1, "R10 enum gate");
      drive(1'b1, 16'h0606, 0, 2'd0, 0, 2'd1);
      n = push_enum(16'h0000, 3, 2'd1, 2'd0, "R10 enum empty");
      drive(1'b1, 16'h0000, 3, 2'd1, 0, 2'd0);
      n = push_enum(16'hFFFE, 0, 2'd2, 2'd0, "R10 enum no free line");
      drive(1'b1, 16'hFFFE, 0, 2'd2, 0, 2'd0);

      // R11: offer a request every busy cycle of an enumeration
      n = push_enum(16'h2C01, 9, 2'd1, 2'd0, "R11 enum under pressure");
      drive(1'b1, 16'h2C01, 9, 2'd1, 0, 2'd0);
      busy = 0;
      while (!ready) begin
         busy++;
         req_enum = 1'b0; req_ctrl_mask = 16'h0001; req_target = 4'd2;
         req_fault = 2'd0; req_fill = 2'd1; req_valid = 1'b1;
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(busy == n, "R11 busy cycles", busy, n);

      single(16'h0300, 0, 2'd1, 9, 2'd2, "R6 random after enumeration");
      repeat (4) @(negedge clk);
      chk(sb_q.size() == 0, "R11 all outputs seen", sb_q.size(), 0);
      report();
   end
endmodule